// File: doc/BRIEF.md
# Queue-register assisted 32-bit shift unit

This execution unit carries out a family of legacy word shifts that work alongside an auxiliary queue register held inside the block. Each operation takes a source word, a shift count and the current queue value. It returns a result word, an arithmetic carry and an optional 4-bit condition field. Most operations also leave a rotated copy of the source in the queue register. The "merge" and "long" variants fill the vacated result bits from the old queue contents under a mask that depends on the count.

The count arrives on a 6-bit operand. The low 5 bits give the shift distance. When the count comes from a register, bit 5 selects an extended behaviour for some operations. When `imm_sel` marks an immediate-field count, bit 5 is ignored. The result, carry and condition field are combinational. The queue register is written on a clock edge while `valid` is high, and it is cleared by a synchronous active-high reset.

Top module: `mqsh_unit`

## Requirements
- R1: `op` codes are: 0 plain left, 1 merge left, 2 queued left, 3 long left, 4 plain right, 5 merge right, 6 queued right, 7 long right, 8 arithmetic right, 9 arithmetic queued right. Codes 10 to 15 give result 0, carry 0, and leave the queue register unchanged. The distance n is `count[4:0]`. The extended flag is `count[5]` when `imm_sel`=0 and is always 0 when `imm_sel`=1.
- R2: Plain left (0) and queued left (2) give result = src << n and queue = src rotated left by n. For queued left with the extended flag set, the result is 0.
- R3: Plain right (4) and queued right (6) give result = src >> n (logical) and queue = src rotated right by n. For queued right with the extended flag set, the result is 0.
- R4: Merge left (1) forms a mask of all-ones << n and a rotation r = src rotated left by n. It gives result = (r & mask) | (old queue & ~mask) and queue = r.
- R5: Merge right (5) works like R4 but with mask = all-ones >> n and r = src rotated right by n.
- R6: Long left (3) takes mask = all-ones << n. With the extended flag set, result = old queue & mask. Otherwise result = (src << n) | (old queue & ~mask). The queue register is not changed.
- R7: Long right (7) takes mask = all-ones >> n. With the extended flag set, result = old queue & mask. Otherwise result = (src >> n) | (old queue & ~mask). The queue register is not changed.
- R8: Arithmetic right (8) gives result = src shifted right arithmetically by n and queue = src rotated right by n. Carry is 0.
- R9: Arithmetic queued right (9) gives queue = src rotated right by n. The result is the arithmetic shift by n, or every bit equal to the sign bit when the extended flag is set. Carry is 1 only when src is negative and a 1-bit was shifted out; with the extended flag set, every source bit counts as shifted out.
- R10: Carry is 0 for every op other than 9.
- R11: With `rec`=1, `cr` = {result negative, result positive, result zero, so_in} from bit 3 down to bit 0. With `rec`=0, `cr` is 0.
- R12: The queue register resets to 0 and is written only on a clock edge with `valid`=1.
- R13: A count of 0 returns the source unchanged and leaves it unrotated in the queue. A count of 31 leaves only the single surviving source bit in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Commits the queue update on this edge |
| op | input | 4 | Operation code (R1) |
| count | input | 6 | Shift distance and extended flag |
| imm_sel | input | 1 | Count comes from an immediate field; ignore bit 5 |
| src | input | 32 | Source word |
| rec | input | 1 | Request condition field |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| result | output | 32 | Result word |
| carry | output | 1 | Arithmetic carry |
| cr | output | 4 | Condition field |
| mq | output | 32 | Queue register contents |

## Verification
The vector table uses a source with a set sign bit and ones at both ends. This shows whether rotated bits wrap into the correct end, and whether an arithmetic shift fills with the sign where a logical shift fills with zeros. A queue value whose bytes are all distinct shows exactly which old-queue bits a mask lets into the result. Each operation is tried at counts 0, 4, 8 and 31, with the extended flag both set and suppressed by the immediate select. Positive, negative-with-lost-ones and negative-with-lost-zeros sources separate the three carry outcomes.

// File: rtl/mqsh_pkg.sv
package mqsh_pkg;
  typedef enum logic [3:0] {
    OP_SL_PLAIN  = 4'd0,
    OP_SL_MERGE  = 4'd1,
    OP_SL_QUEUE  = 4'd2,
    OP_SL_LONG   = 4'd3,
    OP_SR_PLAIN  = 4'd4,
    OP_SR_MERGE  = 4'd5,
    OP_SR_QUEUE  = 4'd6,
    OP_SR_LONG   = 4'd7,
    OP_SRA_PLAIN = 4'd8,
    OP_SRA_QUEUE = 4'd9
  } mqsh_op_e;
endpackage

// File: rtl/mqsh_shifter.sv
module mqsh_shifter #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [CW-1:0] n,
  output logic [W-1:0]  shl,
  output logic [W-1:0]  shr,
  output logic [W-1:0]  sra,
  output logic [W-1:0]  rotl,
  output logic [W-1:0]  rotr,
  output logic [W-1:0]  mask_l,
  output logic [W-1:0]  mask_r
);
  logic [2*W-1:0] dbl_l, dbl_r;

  always_comb begin
    dbl_l  = {src, src} << n;
    dbl_r  = {src, src} >> n;
    rotl   = dbl_l[2*W-1:W];
    rotr   = dbl_r[W-1:0];
    shl    = src << n;
    shr    = src >> n;
    sra    = $signed(src) >>> n;
    mask_l = {W{1'b1}} << n;
    mask_r = {W{1'b1}} >> n;
  end
endmodule

// File: rtl/mqsh_select.sv
module mqsh_select
  import mqsh_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic         ext,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mq_old,
  input  logic [W-1:0] shl,
  input  logic [W-1:0] shr,
  input  logic [W-1:0] sra,
  input  logic [W-1:0] rotl,
  input  logic [W-1:0] rotr,
  input  logic [W-1:0] mask_l,
  input  logic [W-1:0] mask_r,
  output logic [W-1:0] res,
  output logic [W-1:0] mq_nxt,
  output logic         mq_we,
  output logic         carry
);
  mqsh_op_e opc;
  logic     lost_ones;

  always_comb begin
    opc       = mqsh_op_e'(op);
    lost_ones = ext ? (|src) : (|(src & ~mask_l));
    res       = '0;
    mq_nxt    = mq_old;
    mq_we     = 1'b0;
    carry     = 1'b0;
    case (opc)
      OP_SL_PLAIN: begin
        res = shl; mq_nxt = rotl; mq_we = 1'b1;
      end
      OP_SL_QUEUE: begin
        res = ext ? '0 : shl; mq_nxt = rotl; mq_we = 1'b1;
      end
      OP_SL_MERGE: begin
        res = (rotl & mask_l) | (mq_old & ~mask_l); mq_nxt = rotl; mq_we = 1'b1;
      end
      OP_SL_LONG: begin
        res = ext ? (mq_old & mask_l) : (shl | (mq_old & ~mask_l));
      end
      OP_SR_PLAIN: begin
        res = shr; mq_nxt = rotr; mq_we = 1'b1;
      end
      OP_SR_QUEUE: begin
        res = ext ? '0 : shr; mq_nxt = rotr; mq_we = 1'b1;
      end
      OP_SR_MERGE: begin
        res = (rotr & mask_r) | (mq_old & ~mask_r); mq_nxt = rotr; mq_we = 1'b1;
      end
      OP_SR_LONG: begin
        res = ext ? (mq_old & mask_r) : (shr | (mq_old & ~mask_r));
      end
      OP_SRA_PLAIN: begin
        res = sra; mq_nxt = rotr; mq_we = 1'b1;
      end
      OP_SRA_QUEUE: begin
        res    = ext ? {W{src[W-1]}} : sra;
        mq_nxt = rotr;
        mq_we  = 1'b1;
        carry  = src[W-1] & lost_ones;
      end
      default: begin
        res = '0;
      end
    endcase
  end
endmodule

// File: rtl/mqsh_cond.sv
module mqsh_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         rec,
  input  logic         so_in,
  output logic [3:0]   cr
);
  logic neg, zero;

  always_comb begin
    neg  = res[W-1];
    zero = (res == '0);
    cr   = rec ? {neg, ~neg & ~zero, zero, so_in} : 4'b0000;
  end
endmodule

// File: rtl/mqsh_unit.sv
module mqsh_unit
  import mqsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [3:0]    op,
  input  logic [CW:0]   count,
  input  logic          imm_sel,
  input  logic [W-1:0]  src,
  input  logic          rec,
  input  logic          so_in,
  output logic [W-1:0]  result,
  output logic          carry,
  output logic [3:0]    cr,
  output logic [W-1:0]  mq
);
  logic [CW-1:0] n;
  logic          ext;
  logic [W-1:0]  shl, shr, sra, rotl, rotr, mask_l, mask_r;
  logic [W-1:0]  mq_q, mq_nxt;
  logic          mq_we;

  assign n   = count[CW-1:0];
  assign ext = count[CW] & ~imm_sel;

  mqsh_shifter #(.W(W), .CW(CW)) u_shift (
    .src(src), .n(n), .shl(shl), .shr(shr), .sra(sra),
    .rotl(rotl), .rotr(rotr), .mask_l(mask_l), .mask_r(mask_r)
  );

  mqsh_select #(.W(W)) u_sel (
    .op(op), .ext(ext), .src(src), .mq_old(mq_q),
    .shl(shl), .shr(shr), .sra(sra), .rotl(rotl), .rotr(rotr),
    .mask_l(mask_l), .mask_r(mask_r),
    .res(result), .mq_nxt(mq_nxt), .mq_we(mq_we), .carry(carry)
  );

  mqsh_cond #(.W(W)) u_cond (
    .res(result), .rec(rec), .so_in(so_in), .cr(cr)
  );

  always_ff @(posedge clk) begin
    if (rst)                mq_q <= '0;
    else if (valid && mq_we) mq_q <= mq_nxt;
  end

  assign mq = mq_q;

  // R12
  mq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(mq));

  // R6 R7
  mq_long_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && (op == 4'd3 || op == 4'd7)) |=> $stable(mq));

  // R10
  carry_scope_chk: assert property (@(posedge clk) disable iff (rst)
    carry |-> (op == 4'd9));

  // R11
  cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rec |-> ($countones(cr[3:1]) == 1 && cr[0] == so_in));

  // R11
  cr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rec |-> (cr == 4'b0000));

  // R2
  queued_left_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd2 && count[CW] && !imm_sel) |-> (result == '0));

  // R13
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 && count[CW-1:0] == '0) |-> (result == src));
endmodule

// File: tb/sim_mqsh_unit.sv
module sim_mqsh_unit;
  logic        clk = 1'b0;
  logic        rst, valid, imm_sel, rec, so_in;
  logic [3:0]  op;
  logic [5:0]  count;
  logic [31:0] src;
  logic [31:0] result, mq;
  logic        carry;
  logic [3:0]  cr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mqsh_unit u0 (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .count(count),
    .imm_sel(imm_sel), .src(src), .rec(rec), .so_in(so_in),
    .result(result), .carry(carry), .cr(cr), .mq(mq)
  );

  localparam logic [31:0] A = 32'h8000_00F1;
  localparam logic [31:0] Q = 32'h1234_5678;
  localparam int NV = 22;
  // {op, count, imm_sel, src, mq_before, exp_result, exp_mq, exp_carry}
  localparam logic [139:0] VEC [NV] = '{
    {4'd0, 6'h04, 1'b0, A, Q, 32'h0000_0F10, 32'h0000_0F18, 1'b0},
    {4'd2, 6'h24, 1'b0, A, Q, 32'h0000_0000, 32'h0000_0F18, 1'b0},
    {4'd2, 6'h24, 1'b1, A, Q, 32'h0000_0F10, 32'h0000_0F18, 1'b0},
    {4'd1, 6'h08, 1'b0, A, Q, 32'h0000_F178, 32'h0000_F180, 1'b0},
    {4'd3, 6'h08, 1'b0, A, Q, 32'h0000_F178, Q,             1'b0},
    {4'd3, 6'h28, 1'b0, A, Q, 32'h1234_5600, Q,             1'b0},
    {4'd4, 6'h04, 1'b0, A, Q, 32'h0800_000F, 32'h1800_000F, 1'b0},
    {4'd6, 6'h24, 1'b0, A, Q, 32'h0000_0000, 32'h1800_000F, 1'b0},
    {4'd5, 6'h08, 1'b0, A, Q, 32'h1280_0000, 32'hF180_0000, 1'b0},
    {4'd7, 6'h08, 1'b0, A, Q, 32'h1280_0000, Q,             1'b0},
    {4'd7, 6'h28, 1'b0, A, Q, 32'h0034_5678, Q,             1'b0},
    {4'd8, 6'h04, 1'b0, A, Q, 32'hF800_000F, 32'h1800_000F, 1'b0},
    {4'd9, 6'h04, 1'b0, A, Q, 32'hF800_000F, 32'h1800_000F, 1'b1},
    {4'd9, 6'h24, 1'b0, A, Q, 32'hFFFF_FFFF, 32'h1800_000F, 1'b1},
    {4'd9, 6'h20, 1'b1, A, Q, A,             A,             1'b0},
    {4'd9, 6'h04, 1'b0, 32'h0000_00F1, Q, 32'h0000_000F, 32'h1000_000F, 1'b0},
    {4'd9, 6'h04, 1'b0, 32'h8000_00F0, Q, 32'hF800_000F, 32'h0800_000F, 1'b0},
    {4'd1, 6'h00, 1'b0, A, Q, A,             A,             1'b0},
    {4'd4, 6'h1F, 1'b0, A, Q, 32'h0000_0001, 32'h0000_01E3, 1'b0},
    {4'd0, 6'h1F, 1'b0, A, Q, 32'h8000_0000, 32'hC000_0078, 1'b0},
    {4'd7, 6'h20, 1'b0, A, Q, Q,             Q,             1'b0},
    {4'd12,6'h04, 1'b0, A, Q, 32'h0000_0000, Q,             1'b0}
  };

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd2: return "R2";
      4'd4, 4'd6: return "R3";
      4'd1:       return "R4";
      4'd5:       return "R5";
      4'd3:       return "R6";
      4'd7:       return "R7";
      4'd8:       return "R8";
      4'd9:       return "R9";
      default:    return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [5:0] c, input logic im,
                       input logic [31:0] s, input logic v);
    @(negedge clk);
    op = o; count = c; imm_sel = im; src = s; valid = v;
  endtask

  task automatic load_mq(input logic [31:0] v);
    drive(4'd0, 6'h00, 1'b0, v, 1'b1);
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; valid = 1'b0; op = 4'd0; count = 6'd0; imm_sel = 1'b0;
    src = '0; rec = 1'b0; so_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R12 reset value of the queue register
    check("R12 reset", mq, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [139:0] v;
      v = VEC[i];
      load_mq(v[96:65]);
      drive(v[139:136], v[135:130], v[129], v[128:97], 1'b0);
      #2;
      check({tag_of(v[139:136]), " result"}, result, v[64:33]);
      // R10 carry for every op, R9 for op 9
      check({tag_of(v[139:136]), " R10 carry"}, {31'b0, carry}, {31'b0, v[0]});
      valid = 1'b1;
      @(posedge clk); #1;
      check({tag_of(v[139:136]), " queue"}, mq, v[32:1]);
    end

    // R12 no write without valid
    load_mq(Q);
    drive(4'd0, 6'h04, 1'b0, A, 1'b0);
    @(posedge clk); #1;
    check("R12 hold without valid", mq, Q);

    // R13 zero count through the plain right path
    drive(4'd4, 6'h00, 1'b0, A, 1'b1);
    #2;
    check("R13 zero count result", result, A);
    @(posedge clk); #1;
    check("R13 zero count queue", mq, A);

    // R11 condition field
    drive(4'd0, 6'h00, 1'b0, A, 1'b0);
    rec = 1'b1; so_in = 1'b1; #2;
    check("R11 negative", {28'b0, cr}, 32'h9);
    drive(4'd2, 6'h24, 1'b0, A, 1'b0);
    so_in = 1'b0; #2;
    check("R11 zero", {28'b0, cr}, 32'h2);
    drive(4'd4, 6'h04, 1'b0, A, 1'b0);
    #2;
    check("R11 positive", {28'b0, cr}, 32'h4);
    rec = 1'b0; so_in = 1'b1; #2;
    check("R11 not recorded", {28'b0, cr}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule